// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible register file of a color LCD controller. It sits on a simple 32-bit bus with word addresses covering a 4 KB window. It holds four panel timing words, the frame base addresses for the upper and lower panel halves, a control word, an interrupt mask and a raw interrupt status. The raw status bits are set by hardware event pulses and cleared by writing ones. It also returns eight read-only identification bytes.

Downstream logic gets the active panel width and height directly. These are derived from the timing words when those words are written. The block also provides a display-enable flag and the pixel-depth code from the control word. Palette storage lives in a separate block. This bank only decodes the palette address range, forwards the access strobes and returns the palette's read data.

A `VERSION` parameter selects the variant. With `VERSION` 0 the control word is at word 7 and the interrupt mask at word 6. Any other value swaps those two addresses. `VERSION` 2 also changes the identification bytes.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset, every stored register reads zero, and `panel_cols`, `panel_rows`, `disp_en`, `bpp_mode`, `irq` and `bus_err` are all zero.
- R2: Words 0 to 3 (timing) and words 4 and 5 (upper and lower frame base) store all 32 bits when written. A read returns the stored value on `bus_rdata` in the cycle after the access, and that value is held until the next read.
- R3: A write to word 0 sets `panel_cols` to ((data AND 0xFC) + 4) * 4 in the next cycle.
- R4: A write to word 1 sets `panel_rows` to (data AND 0x3FF) + 1 in the next cycle.
- R5: With `VERSION` 0, word 7 is the 32-bit control word and word 6 is the interrupt mask. For any other `VERSION`, the two addresses are swapped, for both reads and writes. The mask keeps only its low `IRQ_W` bits (5 by default), and the higher bits read zero.
- R6: `disp_en` is 1 only when control bit 0 and control bit 11 are both 1. `bpp_mode` equals control bits 3:1.
- R7: A 1 on an `irq_set` bit sets that raw status bit. Word 8 reads the raw status, and word 9 reads the raw status AND the mask. `irq` is 1 exactly when that masked value is nonzero.
- R8: A write to word 10 clears every raw status bit whose data bit is 1. If a set pulse and a clear of the same bit happen in the same cycle, the bit stays set.
- R9: Word 11 reads the upper frame base, and word 12 reads the lower frame base.
- R10: Words 1016 to 1023 read one identification byte each, indexed by word address bits 2:0. `VERSION` 2 returns 11,11,24,00,0D,F0,05,B1 (hex). Other versions return 10,11,04,00,0D,F0,05,B1.
- R11: An access to words 128 to 255 raises `pal_we` (write) or `pal_re` (read) in the same cycle, with `pal_index` equal to word address bits 6:0. A read there returns `pal_rdata`.
- R12: The following accesses are illegal: any undefined word, a read of word 10, and a write to words 8, 9, 11, 12 or the identification words. An illegal access returns zero on a read, changes no state on a write, and raises `bus_err` for exactly the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| pal_we | output | 1 | Palette write strobe |
| pal_re | output | 1 | Palette read strobe |
| pal_index | output | 7 | Palette word index |
| pal_rdata | input | 32 | Palette read data |
| irq_set | input | IRQ_W | Status set pulses from hardware |
| irq | output | 1 | Masked status is nonzero |
| panel_cols | output | 11 | Active width in pixels |
| panel_rows | output | 11 | Active height in lines |
| disp_en | output | 1 | Enable and power bits both set |
| bpp_mode | output | 3 | Pixel-depth code |

## Verification
The hardest case to reach from the ports is a set pulse landing in the same clock cycle as a write-one-to-clear of the same status bit. The bench drives `irq_set` and the clear write on the same falling edge, so both are sampled by one rising edge. A read-back then shows which one took effect. The undefined space is swept word by word, which exercises every illegal case. Reading back every stored register afterwards proves that none of those writes changed state. Two instances with different `VERSION` values show the control and mask address swap and both identification sets.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int WADDR_W   = 10;
  localparam int DIM_W     = 11;
  localparam int ID_BYTES  = 8;
  localparam int VER_ORIG  = 0;
  localparam int VER_LATER = 2;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PWR_BIT = 11;

  typedef enum logic [3:0] {
    K_TIM, K_UBASE, K_LBASE, K_MASK, K_CTRL, K_RAW, K_MIS,
    K_CLR, K_UCUR, K_LCUR, K_PAL, K_ID, K_NONE
  } reg_kind_e;
endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
  import lcdc_pkg::*;
#(
  parameter int VERSION = 0
) (
  input  logic [WADDR_W-1:0] waddr,
  input  logic               is_wr,
  output reg_kind_e          kind,
  output logic               bad
);
  localparam bit SWAP = (VERSION != VER_ORIG);

  always_comb begin
    kind = K_NONE;
    if (waddr >= 10'd128 && waddr < 10'd256) begin
      kind = K_PAL;
    end else if (waddr >= 10'd1016) begin
      kind = K_ID;
    end else begin
      case (waddr)
        10'd0, 10'd1, 10'd2, 10'd3: kind = K_TIM;
        10'd4:  kind = K_UBASE;
        10'd5:  kind = K_LBASE;
        10'd6:  kind = SWAP ? K_CTRL : K_MASK;
        10'd7:  kind = SWAP ? K_MASK : K_CTRL;
        10'd8:  kind = K_RAW;
        10'd9:  kind = K_MIS;
        10'd10: kind = K_CLR;
        10'd11: kind = K_UCUR;
        10'd12: kind = K_LCUR;
        default: kind = K_NONE;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_NONE:                              bad = 1'b1;
      K_RAW, K_MIS, K_UCUR, K_LCUR, K_ID:  bad = is_wr;
      K_CLR:                               bad = ~is_wr;
      default:                             bad = 1'b0;
    endcase
  end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
  import lcdc_pkg::*;
(
  input  logic [5:0]       col_field,
  input  logic [9:0]       row_field,
  output logic [DIM_W-1:0] col_calc,
  output logic [DIM_W-1:0] row_calc
);
  // ((x AND 0xFC) + 4) * 4 == (x[7:2] + 1) * 16
  always_comb begin
    col_calc = (DIM_W'(col_field) + DIM_W'(1)) << 4;
    row_calc = DIM_W'(row_field) + DIM_W'(1);
  end
endmodule

// File: rtl/lcdc_id_rom.sv
module lcdc_id_rom
  import lcdc_pkg::*;
#(
  parameter int VERSION = 0
) (
  input  logic [$clog2(ID_BYTES)-1:0] idx,
  output logic [7:0]                  id_byte
);
  logic [7:0] head0, head2;

  generate
    if (VERSION == VER_LATER) begin : g_later
      assign head0 = 8'h11;
      assign head2 = 8'h24;
    end else begin : g_orig
      assign head0 = 8'h10;
      assign head2 = 8'h04;
    end
  endgenerate

  always_comb begin
    case (idx)
      3'd0: id_byte = head0;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = head2;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter int VERSION = 0,
  parameter int IRQ_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [9:0]         bus_waddr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_err,
  output logic               pal_we,
  output logic               pal_re,
  output logic [6:0]         pal_index,
  input  logic [31:0]        pal_rdata,
  input  logic [IRQ_W-1:0]   irq_set,
  output logic               irq,
  output logic [10:0]        panel_cols,
  output logic [10:0]        panel_rows,
  output logic               disp_en,
  output logic [2:0]         bpp_mode
);
  localparam int NUM_TIM = 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  // decode
  reg_kind_e kind;
  logic      bad;
  lcdc_decode #(.VERSION(VERSION)) u_decode (
    .waddr (bus_waddr),
    .is_wr (bus_wr),
    .kind  (kind),
    .bad   (bad)
  );

  logic [DIM_W-1:0] col_calc, row_calc;
  lcdc_geom u_geom (
    .col_field (bus_wdata[7:2]),
    .row_field (bus_wdata[9:0]),
    .col_calc  (col_calc),
    .row_calc  (row_calc)
  );

  logic [7:0] id_byte;
  lcdc_id_rom #(.VERSION(VERSION)) u_id (
    .idx     (bus_waddr[2:0]),
    .id_byte (id_byte)
  );

  // state
  logic [31:0]      tim_q [NUM_TIM];
  logic [31:0]      ubase_q, lbase_q, ctrl_q, rdata_q;
  logic [IRQ_W-1:0] mask_q, raw_q, raw_d;
  logic [DIM_W-1:0] cols_q, rows_q;
  logic             err_q;

  // enables
  logic wr_ok, rd_acc;
  logic ubase_en, lbase_en, ctrl_en, mask_en, clr_en;
  logic [31:0] rdata_d;

  always_comb begin
    wr_ok    = bus_sel & bus_wr & ~bad;
    rd_acc   = bus_sel & ~bus_wr;
    ubase_en = wr_ok & (kind == K_UBASE);
    lbase_en = wr_ok & (kind == K_LBASE);
    ctrl_en  = wr_ok & (kind == K_CTRL);
    mask_en  = wr_ok & (kind == K_MASK);
    clr_en   = wr_ok & (kind == K_CLR);
    raw_d    = (raw_q & ~(clr_en ? bus_wdata[IRQ_W-1:0] : '0)) | irq_set;
  end

  always_comb begin
    case (kind)
      K_TIM:          rdata_d = tim_q[bus_waddr[1:0]];
      K_UBASE, K_UCUR: rdata_d = ubase_q;
      K_LBASE, K_LCUR: rdata_d = lbase_q;
      K_MASK:         rdata_d = 32'(mask_q);
      K_CTRL:         rdata_d = ctrl_q;
      K_RAW:          rdata_d = 32'(raw_q);
      K_MIS:          rdata_d = 32'(raw_q & mask_q);
      K_PAL:          rdata_d = pal_rdata;
      K_ID:           rdata_d = {24'd0, id_byte};
      default:        rdata_d = 32'd0;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TIM; gi++) begin : g_tim
      logic tim_en;
      assign tim_en = wr_ok & (kind == K_TIM) & (bus_waddr[1:0] == 2'(gi));
      always_ff @(posedge clk or negedge rst_n_sync) begin
        if (!rst_n_sync)  tim_q[gi] <= '0;
        else if (tim_en)  tim_q[gi] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ubase_q <= '0;
      lbase_q <= '0;
      ctrl_q  <= '0;
      mask_q  <= '0;
      raw_q   <= '0;
      cols_q  <= '0;
      rows_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (ubase_en) ubase_q <= bus_wdata;
      if (lbase_en) lbase_q <= bus_wdata;
      if (ctrl_en)  ctrl_q  <= bus_wdata;
      if (mask_en)  mask_q  <= bus_wdata[IRQ_W-1:0];
      raw_q <= raw_d;
      if (wr_ok && kind == K_TIM && bus_waddr[1:0] == 2'd0) cols_q <= col_calc;
      if (wr_ok && kind == K_TIM && bus_waddr[1:0] == 2'd1) rows_q <= row_calc;
      if (rd_acc)   rdata_q <= rdata_d;
      err_q <= bus_sel & bad;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_err    = err_q;
  assign pal_we     = bus_sel &  bus_wr & (kind == K_PAL);
  assign pal_re     = bus_sel & ~bus_wr & (kind == K_PAL);
  assign pal_index  = bus_waddr[6:0];
  assign irq        = |(raw_q & mask_q);
  assign panel_cols = cols_q;
  assign panel_rows = rows_q;
  assign disp_en    = ctrl_q[CTRL_EN_BIT] & ctrl_q[CTRL_PWR_BIT];
  assign bpp_mode   = ctrl_q[3:1];
endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk #(
  parameter int IRQ_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [9:0]       bus_waddr,
  input logic [31:0]      bus_wdata,
  input logic [IRQ_W-1:0] irq_set,
  input logic             irq,
  input logic             bus_err,
  input logic [10:0]      panel_cols,
  input logic [10:0]      panel_rows,
  input logic             disp_en,
  input logic             pal_we,
  input logic             pal_re
);
  assert_cols_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 10'd0)
      |=> panel_cols == ((11'($past(bus_wdata[7:2])) + 11'd1) << 4));

  assert_rows_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 10'd1)
      |=> panel_rows == 11'($past(bus_wdata[9:0])) + 11'd1);

  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(disp_en));

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr == 10'd10 &&
     bus_wdata[IRQ_W-1:0] == {IRQ_W{1'b1}} && irq_set == '0) |=> !irq);

  assert_err_follows_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  assert_pal_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pal_we, pal_re}));
endmodule

bind lcdc_regbank lcdc_regbank_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_waddr  (bus_waddr),
  .bus_wdata  (bus_wdata),
  .irq_set    (irq_set),
  .irq        (irq),
  .bus_err    (bus_err),
  .panel_cols (panel_cols),
  .panel_rows (panel_rows),
  .disp_en    (disp_en),
  .pal_we     (pal_we),
  .pal_re     (pal_re)
);

// File: tb/tb_lcdc_regbank.sv
`timescale 1ns/1ps
module tb_lcdc_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        sel_a = 0, sel_b = 0, wr_en = 0;
  logic [9:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  set_v = '0;

  logic [31:0] rdata_a, rdata_b, prd_a, prd_b;
  logic        err_a, err_b, pwe_a, pwe_b, pre_a, pre_b, irq_a, irq_b;
  logic        en_a, en_b;
  logic [6:0]  pix_a, pix_b;
  logic [10:0] cols_a, cols_b, rows_a, rows_b;
  logic [2:0]  bpp_a, bpp_b;

  assign prd_a = 32'hC0DE_0000 | 32'(pix_a);
  assign prd_b = 32'hC0DE_0000 | 32'(pix_b);

  lcdc_regbank #(.VERSION(0), .IRQ_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr_en), .bus_waddr(waddr),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .bus_err(err_a), .pal_we(pwe_a),
    .pal_re(pre_a), .pal_index(pix_a), .pal_rdata(prd_a), .irq_set(set_v),
    .irq(irq_a), .panel_cols(cols_a), .panel_rows(rows_a), .disp_en(en_a),
    .bpp_mode(bpp_a));

  lcdc_regbank #(.VERSION(2), .IRQ_W(5)) dut_alt (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr_en), .bus_waddr(waddr),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .bus_err(err_b), .pal_we(pwe_b),
    .pal_re(pre_b), .pal_index(pix_b), .pal_rdata(prd_b), .irq_set(5'd0),
    .irq(irq_b), .panel_cols(cols_b), .panel_rows(rows_b), .disp_en(en_b),
    .bpp_mode(bpp_b));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input bit alt, input int w, input logic [31:0] d, output logic e);
    @(negedge clk);
    waddr = 10'(w); wdata = d; wr_en = 1'b1;
    if (alt) sel_b = 1'b1; else sel_a = 1'b1;
    @(negedge clk);
    sel_a = 0; sel_b = 0; wr_en = 0;
    e = alt ? err_b : err_a;
  endtask

  task automatic brd(input bit alt, input int w, output logic [31:0] d, output logic e);
    @(negedge clk);
    waddr = 10'(w); wr_en = 1'b0;
    if (alt) sel_b = 1'b1; else sel_a = 1'b1;
    @(negedge clk);
    sel_a = 0; sel_b = 0;
    d = alt ? rdata_b : rdata_a;
    e = alt ? err_b : err_a;
  endtask

  function automatic logic [7:0] id_exp(input bit later, input int i);
    case (i)
      0: return later ? 8'h11 : 8'h10;
      1: return 8'h11;
      2: return later ? 8'h24 : 8'h04;
      3: return 8'h00;
      4: return 8'h0D;
      5: return 8'hF0;
      6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cols", 32'(cols_a), 0);
    check("R1 rows", 32'(rows_a), 0);
    check("R1 en", 32'(en_a), 0);
    check("R1 bpp", 32'(bpp_a), 0);
    check("R1 irq", 32'(irq_a), 0);
    check("R1 err", 32'(err_a), 0);
    for (int w = 0; w < 13; w++) begin
      if (w == 10) continue;
      brd(0, w, d, e);
      check("R1 reg", d, 0);
    end

    // R3 column sweep
    for (int v = 0; v < 256; v++) begin
      bwr(0, 0, 32'hFFFF_FF00 | 32'(v), e);
      check("R3 cols", 32'(cols_a), 32'(((v & 'hFC) + 4) * 4));
    end
    // R4 row sweep
    for (int v = 0; v < 1024; v++) begin
      bwr(0, 1, 32'hFFFF_FC00 | 32'(v), e);
      check("R4 rows", 32'(rows_a), 32'(v + 1));
    end

    // R2 storage and hold
    for (int w = 0; w < 6; w++) begin
      bwr(0, w, 32'hA5A5_0000 ^ (32'(w) * 32'h0101_1111), e);
      check("R2 wr err", 32'(e), 0);
    end
    for (int w = 0; w < 6; w++) begin
      brd(0, w, d, e);
      check("R2 readback", d, 32'hA5A5_0000 ^ (32'(w) * 32'h0101_1111));
    end
    repeat (3) @(negedge clk);
    check("R2 hold", rdata_a, 32'hA5A5_0000 ^ (32'd5 * 32'h0101_1111));
    bwr(0, 4, 32'h1234_5678, e);
    bwr(0, 5, 32'h8765_4320, e);

    // R9 current address
    brd(0, 11, d, e); check("R9 upper cur", d, 32'h1234_5678);
    brd(0, 12, d, e); check("R9 lower cur", d, 32'h8765_4320);

    // R5 address swap and mask width
    bwr(0, 7, 32'h0000_0806, e);
    bwr(0, 6, 32'hFFFF_FFF5, e);
    brd(0, 7, d, e); check("R5 ctrl v0", d, 32'h0000_0806);
    brd(0, 6, d, e); check("R5 mask v0", d, 32'h15);
    bwr(1, 6, 32'h0000_0801, e);
    bwr(1, 7, 32'h0000_000A, e);
    brd(1, 6, d, e); check("R5 ctrl v2", d, 32'h0000_0801);
    brd(1, 7, d, e); check("R5 mask v2", d, 32'h0A);
    check("R6 en v2", 32'(en_b), 1);

    // R6 enable combos and pixel depth
    for (int c = 0; c < 4; c++) begin
      bwr(0, 7, (32'(c & 1)) | (32'((c >> 1) & 1) << 11) | (32'(c) << 1), e);
      check("R6 en", 32'(en_a), 32'(c == 3));
      check("R6 bpp", 32'(bpp_a), 32'((c << 0) & 7));
    end
    bwr(0, 7, 32'h0000_080F, e);
    check("R6 bpp7", 32'(bpp_a), 7);

    // R7 status, masked, irq
    bwr(0, 6, 32'h05, e);
    @(negedge clk) set_v = 5'b00110;
    @(negedge clk) set_v = 5'b00000;
    brd(0, 8, d, e); check("R7 raw", d, 32'h06);
    brd(0, 9, d, e); check("R7 masked", d, 32'h04);
    check("R7 irq on", 32'(irq_a), 1);
    // R8 partial clear
    bwr(0, 10, 32'h04, e);
    check("R8 clr err", 32'(e), 0);
    check("R8 irq off", 32'(irq_a), 0);
    brd(0, 8, d, e); check("R8 raw after clr", d, 32'h02);
    // R8 set and clear same cycle
    @(negedge clk);
    waddr = 10'd10; wdata = 32'h08; wr_en = 1; sel_a = 1; set_v = 5'b01000;
    @(negedge clk);
    sel_a = 0; wr_en = 0; set_v = 0;
    brd(0, 8, d, e); check("R8 set wins", d, 32'h0A);
    bwr(0, 10, 32'h1F, e);
    brd(0, 8, d, e); check("R8 clear all", d, 0);

    // R10 identification
    for (int i = 0; i < 8; i++) begin
      brd(0, 1016 + i, d, e); check("R10 id v0", d, 32'(id_exp(0, i)));
      brd(1, 1016 + i, d, e); check("R10 id v2", d, 32'(id_exp(1, i)));
      check("R10 err", 32'(e), 0);
    end

    // R11 palette routing
    @(negedge clk);
    waddr = 10'h80 + 10'h21; wr_en = 1; sel_a = 1; wdata = 32'h5;
    #1;
    check("R11 we", 32'(pwe_a), 1);
    check("R11 re", 32'(pre_a), 0);
    check("R11 index", 32'(pix_a), 32'h21);
    @(negedge clk) begin sel_a = 0; wr_en = 0; end
    brd(0, 255, d, e); check("R11 rdata", d, 32'hC0DE_007F);
    check("R11 err", 32'(e), 0);

    // R12 undefined space
    for (int w = 13; w < 1016; w++) begin
      if (w >= 128 && w < 256) continue;
      brd(0, w, d, e);
      check("R12 undef read", d, 0);
      check("R12 undef err", 32'(e), 1);
    end
    brd(0, 10, d, e); check("R12 clr read err", 32'(e), 1);
    check("R12 clr read data", d, 0);
    @(negedge clk); check("R12 err one cycle", 32'(err_a), 0);
    bwr(0, 13, 32'hFFFF_FFFF, e);  check("R12 undef wr err", 32'(e), 1);
    bwr(0, 500, 32'hFFFF_FFFF, e); check("R12 undef wr err", 32'(e), 1);
    bwr(0, 11, 32'hDEAD_BEEF, e);  check("R12 ro wr err", 32'(e), 1);
    bwr(0, 12, 32'hDEAD_BEEF, e);  check("R12 ro wr err", 32'(e), 1);
    bwr(0, 8, 32'h1F, e);          check("R12 raw wr err", 32'(e), 1);
    bwr(0, 1020, 32'h0, e);        check("R12 id wr err", 32'(e), 1);
    brd(0, 4, d, e); check("R12 upper kept", d, 32'h1234_5678);
    brd(0, 5, d, e); check("R12 lower kept", d, 32'h8765_4320);
    brd(0, 7, d, e); check("R12 ctrl kept", d, 32'h0000_080F);
    brd(0, 6, d, e); check("R12 mask kept", d, 32'h05);
    brd(0, 8, d, e); check("R12 raw kept", d, 0);
    brd(0, 1020, d, e); check("R12 id kept", d, 32'h0D);
    check("R12 irq", 32'(irq_a), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule